// File: doc/BRIEF.md
# Transactional Line Permission Controller

This block keeps, for every tracked cache line, the coherence permission that each of several processor caches holds: Invalid, Shared or Modified. It also keeps one transactional flag per cache per line. Caches send it load-shared reads, load-exclusive writes, evictions, commits and aborts, one at a time, through a single valid/ready request port. For each accepted request it returns a registered response one cycle later. The response gives the grant or refusal, the requester's resulting permission, whether the data comes by cache-to-cache transfer, and which other caches lost permission.

A transactional Shared line works as a read lock and a transactional Modified line works as a write lock. Together these give strong strict two-phase locking on top of the plain reader/writer permission scheme. A request whose mode conflicts with another cache's transactional line is resolved by a static policy input. Under requestor-win, the request is granted and every conflicting holder is aborted. Under refusal mode, the request is negatively acknowledged and the requester is aborted.

Aborting a processor rolls back all of its lines in the same update. Its transactional Modified lines become Invalid, and its transactional Shared lines keep Shared without the flag. Committing clears all of a processor's flags and leaves the permissions as they are.

Top module: `tmsi_perm_ctrl`

## Requirements
- R1: A read (op code 0) on a line that no other cache holds Modified grants Shared (state code 1) to the requester. It revokes nothing and signals no cache-to-cache transfer.
- R2: A read on a line held Modified by another cache without the transactional flag downgrades that holder to Shared. That holder is shown in the revoke mask (bit index = cache number), and the response signals a cache-to-cache transfer.
- R3: A write (op code 1) that is granted invalidates the line in every other cache that holds it, and those caches are shown in the revoke mask. The requester receives Modified (state code 2). A cache-to-cache transfer is signalled when a surviving holder had the line Modified. At most one cache holds a line Modified at any time.
- R4: With the policy input at 0 (requestor-win), a request that conflicts with another cache's transactional line is still granted. A read conflicts with a transactional Modified holder, and a write conflicts with any transactional holder. Each conflicting holder receives an abort pulse and loses the line, and no refusal is ever given.
- R5: With the policy input at 1 (refusal mode), a conflicting request is answered with the refusal flag set and no grant. The abort pulse goes to the requester only, and the holders keep their lines.
- R6: Reads by several caches on the same line, transactional or not, never conflict and never abort anyone.
- R7: A commit (op code 3) clears every transactional flag of the requesting cache in one update and leaves its permissions unchanged. Its former lines then no longer cause conflicts.
- R8: An explicit abort (op code 4) turns the requester's transactional Modified lines Invalid and leaves its transactional Shared lines Shared without the flag. It produces no abort pulse.
- R9: An eviction (op code 2) invalidates the requester's copy of the line. When that copy was transactional, the requester receives an abort pulse; otherwise it does not.
- R10: Every abort that a conflict or an eviction causes rolls back all of the aborted cache's transactional lines in the same update, including the requester in refusal mode.
- R11: Abort pulses last one cycle and appear only together with a response. The revoke mask never includes the requester.
- R12: While reset is held, ready is low and no response appears. After reset, every line is Invalid in every cache, ready is high, and the response to a request accepted on one clock edge is valid after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nack_mode | input | 1 | Static conflict policy: 0 requestor-win, 1 refuse the requester |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_op | input | 3 | 0 read, 1 write, 2 evict, 3 commit, 4 abort |
| req_core | input | CW | Requesting cache number |
| req_line | input | LW | Line index |
| req_tx | input | 1 | Access is part of a transaction |
| resp_valid | output | 1 | Response for the request accepted on the previous edge |
| resp_grant | output | 1 | Request granted |
| resp_nack | output | 1 | Request refused because of a transactional conflict |
| resp_c2c | output | 1 | Data supplied by cache-to-cache transfer |
| resp_state | output | 2 | Requester's resulting state on the line (0 I, 1 S, 2 M) |
| revoke_o | output | CORES | Other caches that lost or downgraded permission |
| abort_o | output | CORES | One-cycle abort pulse per cache |

## Verification
A corrupted permission entry or a stale transactional flag does not show up at once. It shows only when a later request touches the same line or the same cache. A flag that was left set after a commit or an abort shows as an unexpected abort pulse or refusal. A Modified entry that was not rolled back shows as a spurious cache-to-cache transfer or revoke bit. The stimulus therefore follows each commit, abort and eviction with a request that would expose the stale state in the next response. Duplicate ownership is caught in the same cycle by the invariant check on the permission array.

// File: rtl/tmsi_pkg.sv
package tmsi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } lstate_e;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_EVICT  = 3'd2,
        OP_COMMIT = 3'd3,
        OP_ABORT  = 3'd4
    } op_e;

    typedef struct packed {
        lstate_e st;
        logic    tx;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{st: LS_I, tx: 1'b0};

    function automatic logic is_access(op_e op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

    function automatic logic touches_line(op_e op);
        return is_access(op) || (op == OP_EVICT);
    endfunction

endpackage

// File: rtl/tmsi_line_eval.sv
module tmsi_line_eval
    import tmsi_pkg::*;
#(
    parameter int CORES = 4,
    localparam int CW = $clog2(CORES)
) (
    input  op_e                    op,
    input  logic [CW-1:0]          core,
    input  logic                   tx,
    input  logic                   nack_mode,
    input  slot_t [CORES-1:0]      cur,
    output slot_t [CORES-1:0]      nxt,
    output logic  [CORES-1:0]      abort_m,
    output logic  [CORES-1:0]      revoke_m,
    output logic                   grant,
    output logic                   nack,
    output logic                   c2c
);

    logic [CORES-1:0] conf;

    always_comb begin
        conf = '0;
        for (int h = 0; h < CORES; h++) begin
            if (CW'(h) != core && cur[h].tx) begin
                if (op == OP_WRITE && cur[h].st != LS_I) conf[h] = 1'b1;
                if (op == OP_READ  && cur[h].st == LS_M) conf[h] = 1'b1;
            end
        end
    end

    always_comb begin
        nxt      = cur;
        abort_m  = '0;
        revoke_m = '0;
        grant    = 1'b0;
        nack     = 1'b0;
        c2c      = 1'b0;
        case (op)
            OP_READ, OP_WRITE: begin
                if ((|conf) && nack_mode) begin
                    nack          = 1'b1;
                    abort_m[core] = 1'b1;
                end else begin
                    grant   = 1'b1;
                    abort_m = conf;
                    for (int h = 0; h < CORES; h++) begin
                        if (CW'(h) != core) begin
                            if (op == OP_WRITE) begin
                                if (cur[h].st != LS_I) begin
                                    nxt[h]      = SLOT_EMPTY;
                                    revoke_m[h] = 1'b1;
                                    if (cur[h].st == LS_M && !conf[h]) c2c = 1'b1;
                                end
                            end else if (cur[h].st == LS_M) begin
                                revoke_m[h] = 1'b1;
                                if (conf[h]) begin
                                    nxt[h] = SLOT_EMPTY;
                                end else begin
                                    nxt[h] = '{st: LS_S, tx: 1'b0};
                                    c2c    = 1'b1;
                                end
                            end
                        end
                    end
                    if (op == OP_WRITE)
                        nxt[core].st = LS_M;
                    else if (cur[core].st == LS_I)
                        nxt[core].st = LS_S;
                    nxt[core].tx = cur[core].tx | tx;
                end
            end
            OP_EVICT: begin
                grant     = 1'b1;
                nxt[core] = SLOT_EMPTY;
                if (cur[core].tx) abort_m[core] = 1'b1;
            end
            default: grant = 1'b1;
        endcase
    end

endmodule

// File: rtl/tmsi_rollback.sv
module tmsi_rollback
    import tmsi_pkg::*;
#(
    parameter int CORES = 4
) (
    input  slot_t [CORES-1:0] in_line,
    input  logic  [CORES-1:0] rb_mask,
    input  logic  [CORES-1:0] cm_mask,
    output slot_t [CORES-1:0] out_line
);

    for (genvar c = 0; c < CORES; c++) begin : g_slot
        always_comb begin
            out_line[c] = in_line[c];
            if (rb_mask[c] && in_line[c].tx) begin
                out_line[c].tx = 1'b0;
                if (in_line[c].st == LS_M) out_line[c].st = LS_I;
            end else if (cm_mask[c]) begin
                out_line[c].tx = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmsi_perm_ctrl.sv
module tmsi_perm_ctrl
    import tmsi_pkg::*;
#(
    parameter int CORES = 4,
    parameter int LINES = 16,
    localparam int CW = $clog2(CORES),
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nack_mode,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [CW-1:0]    req_core,
    input  logic [LW-1:0]    req_line,
    input  logic             req_tx,
    output logic             resp_valid,
    output logic             resp_grant,
    output logic             resp_nack,
    output logic             resp_c2c,
    output logic [1:0]       resp_state,
    output logic [CORES-1:0] revoke_o,
    output logic [CORES-1:0] abort_o
);

    slot_t [CORES-1:0] dir_q  [LINES];
    slot_t [CORES-1:0] pre_d  [LINES];
    slot_t [CORES-1:0] post_d [LINES];

    op_e               op;
    logic              fire;
    logic [CORES-1:0]  core_oh;
    slot_t [CORES-1:0] cur_line;
    slot_t [CORES-1:0] eval_nxt;
    logic [CORES-1:0]  eval_abort, eval_revoke;
    logic              eval_grant, eval_nack, eval_c2c;
    logic [CORES-1:0]  rb_mask, cm_mask;
    slot_t [CORES-1:0] sel_post;
    logic [LINES*CORES-1:0] m_flat;

    assign op      = op_e'(req_op);
    assign fire    = req_valid && req_ready;
    assign core_oh = CORES'(1) << req_core;

    always_comb begin
        cur_line = dir_q[req_line];
        sel_post = post_d[req_line];
    end

    tmsi_line_eval #(.CORES(CORES)) eval_i (
        .op        (op),
        .core      (req_core),
        .tx        (req_tx),
        .nack_mode (nack_mode),
        .cur       (cur_line),
        .nxt       (eval_nxt),
        .abort_m   (eval_abort),
        .revoke_m  (eval_revoke),
        .grant     (eval_grant),
        .nack      (eval_nack),
        .c2c       (eval_c2c)
    );

    always_comb begin
        rb_mask = '0;
        cm_mask = '0;
        if (fire) begin
            rb_mask = eval_abort | ((op == OP_ABORT) ? core_oh : '0);
            cm_mask = (op == OP_COMMIT) ? core_oh : '0;
        end
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        always_comb begin
            if (fire && touches_line(op) && req_line == LW'(l))
                pre_d[l] = eval_nxt;
            else
                pre_d[l] = dir_q[l];
        end

        tmsi_rollback #(.CORES(CORES)) rb_i (
            .in_line  (pre_d[l]),
            .rb_mask  (rb_mask),
            .cm_mask  (cm_mask),
            .out_line (post_d[l])
        );

        always_ff @(posedge clk) begin
            if (rst) dir_q[l] <= '{default: SLOT_EMPTY};
            else     dir_q[l] <= post_d[l];
        end

        for (genvar c = 0; c < CORES; c++) begin : g_m
            assign m_flat[l*CORES+c] = (dir_q[l][c].st == LS_M);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_ready  <= 1'b0;
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
            resp_nack  <= 1'b0;
            resp_c2c   <= 1'b0;
            resp_state <= 2'd0;
            revoke_o   <= '0;
            abort_o    <= '0;
        end else begin
            req_ready  <= 1'b1;
            resp_valid <= fire;
            resp_grant <= fire && eval_grant;
            resp_nack  <= fire && eval_nack;
            resp_c2c   <= fire && eval_c2c;
            resp_state <= fire ? sel_post[req_core].st : 2'd0;
            revoke_o   <= fire ? eval_revoke : '0;
            abort_o    <= fire ? eval_abort : '0;
        end
    end

endmodule

// File: rtl/tmsi_perm_chk.sv
module tmsi_perm_chk #(
    parameter int CORES = 4,
    parameter int LINES = 16,
    localparam int CW = $clog2(CORES)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   nack_mode,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [2:0]             req_op,
    input logic [CW-1:0]          req_core,
    input logic                   resp_valid,
    input logic                   resp_grant,
    input logic                   resp_nack,
    input logic [1:0]             resp_state,
    input logic [CORES-1:0]       revoke_o,
    input logic [CORES-1:0]       abort_o,
    input logic [LINES*CORES-1:0] m_flat
);

    logic fire;
    assign fire = req_valid && req_ready;

    for (genvar l = 0; l < LINES; l++) begin : g_inv
        // R3: single writer per line
        p_single_owner_r3: assert property (@(posedge clk) disable iff (rst)
            $countones(m_flat[l*CORES +: CORES]) <= 1);
    end

    p_write_gives_m_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && req_op == 3'd1) |=> (!resp_grant || resp_state == 2'd2));

    p_nack_excl_grant_r5: assert property (@(posedge clk) disable iff (rst)
        resp_nack |-> !resp_grant);

    p_nack_aborts_requester_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && nack_mode && req_op <= 3'd1) |=>
        ((abort_o & ~(CORES'(1) << $past(req_core))) == '0));

    p_winner_never_refused_r4: assert property (@(posedge clk) disable iff (rst)
        !nack_mode |-> !resp_nack);

    p_revoke_not_self_r11: assert property (@(posedge clk) disable iff (rst)
        fire |=> (revoke_o[$past(req_core)] == 1'b0));

    p_abort_with_resp_r11: assert property (@(posedge clk) disable iff (rst)
        (abort_o != '0) |-> resp_valid);

    p_resp_follows_fire_r12: assert property (@(posedge clk) disable iff (rst)
        fire |=> resp_valid);

endmodule

bind tmsi_perm_ctrl tmsi_perm_chk #(.CORES(CORES), .LINES(LINES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .nack_mode  (nack_mode),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_core   (req_core),
    .resp_valid (resp_valid),
    .resp_grant (resp_grant),
    .resp_nack  (resp_nack),
    .resp_state (resp_state),
    .revoke_o   (revoke_o),
    .abort_o    (abort_o),
    .m_flat     (m_flat)
);

// File: tb/tmsi_perm_ctrl_tb_top.sv
module tmsi_perm_ctrl_tb_top;

    localparam int CORES = 4;
    localparam int LINES = 16;
    localparam int VW = 27;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nack_mode = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_op = 3'd0;
    logic [1:0] req_core = 2'd0;
    logic [3:0] req_line = 4'd0;
    logic       req_tx = 1'b0;
    logic       resp_valid, resp_grant, resp_nack, resp_c2c;
    logic [1:0] resp_state;
    logic [3:0] revoke_o, abort_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tmsi_perm_ctrl #(.CORES(CORES), .LINES(LINES)) dut_i (
        .clk(clk), .rst(rst), .nack_mode(nack_mode),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_core(req_core), .req_line(req_line), .req_tx(req_tx),
        .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_nack(resp_nack),
        .resp_c2c(resp_c2c), .resp_state(resp_state),
        .revoke_o(revoke_o), .abort_o(abort_o)
    );

    // fields: op, core, line, tx, grant, nack, state, c2c, revoke, abort, requirement
    function automatic logic [VW-1:0] v(int op, int core, int line, int tx, int g, int n,
                                        int st, int c2c, int rev, int ab, int rq);
        return {3'(op), 2'(core), 4'(line), 1'(tx), 1'(g), 1'(n), 2'(st), 1'(c2c),
                4'(rev), 4'(ab), 4'(rq)};
    endfunction

    // requestor-win table
    localparam logic [VW-1:0] TAB_RW [21] = '{
        v(0,0,1,0, 1,0,1,0,4'b0000,4'b0000, 1),  // R1 empty line
        v(0,1,1,0, 1,0,1,0,4'b0000,4'b0000, 1),  // R1 second sharer
        v(1,2,1,0, 1,0,2,0,4'b0011,4'b0000, 3),  // R3 invalidate sharers
        v(0,3,1,0, 1,0,1,1,4'b0100,4'b0000, 2),  // R2 downgrade owner
        v(1,0,2,1, 1,0,2,0,4'b0000,4'b0000, 3),  // R3 tx write
        v(0,1,2,0, 1,0,1,0,4'b0001,4'b0001, 4),  // R4 read beats tx M
        v(0,1,2,1, 1,0,1,0,4'b0000,4'b0000, 6),  // R6 tx read hit
        v(0,2,2,1, 1,0,1,0,4'b0000,4'b0000, 6),  // R6 read-read tx
        v(1,3,2,0, 1,0,2,0,4'b0110,4'b0110, 4),  // R4 write beats tx S
        v(1,0,3,1, 1,0,2,0,4'b0000,4'b0000, 3),
        v(3,0,3,0, 1,0,2,0,4'b0000,4'b0000, 7),  // R7 commit keeps M
        v(1,1,3,0, 1,0,2,1,4'b0001,4'b0000, 7),  // R7 no abort after commit
        v(1,2,4,1, 1,0,2,0,4'b0000,4'b0000, 3),
        v(0,2,5,1, 1,0,1,0,4'b0000,4'b0000, 1),
        v(4,2,4,0, 1,0,0,0,4'b0000,4'b0000, 8),  // R8 explicit abort
        v(0,3,4,0, 1,0,1,0,4'b0000,4'b0000, 8),  // R8 tx M gone
        v(0,3,5,0, 1,0,1,0,4'b0000,4'b0000, 8),  // R8 S kept
        v(1,3,5,0, 1,0,2,0,4'b0100,4'b0000, 8),  // R8 flag cleared
        v(1,1,6,1, 1,0,2,0,4'b0000,4'b0000, 3),
        v(2,1,6,0, 1,0,0,0,4'b0000,4'b0010, 9),  // R9 tx eviction
        v(2,0,1,0, 1,0,0,0,4'b0000,4'b0000, 9)   // R9 plain eviction
    };

    // refusal-mode table
    localparam logic [VW-1:0] TAB_NK [9] = '{
        v(1,0,7,1, 1,0,2,0,4'b0000,4'b0000, 3),
        v(0,1,7,0, 0,1,0,0,4'b0000,4'b0010, 5),  // R5 refused
        v(0,2,7,0, 0,1,0,0,4'b0000,4'b0100, 5),  // R5 holder kept
        v(3,0,7,0, 1,0,2,0,4'b0000,4'b0000, 7),
        v(0,1,7,0, 1,0,1,1,4'b0001,4'b0000, 5),  // R5 holder still M
        v(1,2,8,1, 1,0,2,0,4'b0000,4'b0000, 3),
        v(1,3,10,1,1,0,2,0,4'b0000,4'b0000, 3),
        v(0,2,10,0,0,1,0,0,4'b0000,4'b0100, 10), // R10 requester aborted
        v(0,0,8,0, 1,0,1,0,4'b0000,4'b0000, 10)  // R10 requester's M rolled back
    };

    task automatic chk(string what, int rq, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic apply(logic [VW-1:0] vec);
        int rq;
        rq = int'(vec[3:0]);
        @(negedge clk);
        req_op    = vec[26:24];
        req_core  = vec[23:22];
        req_line  = vec[21:18];
        req_tx    = vec[17];
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("resp_valid", 12, int'(resp_valid), 1);
        chk("grant",      rq, int'(resp_grant), int'(vec[16]));
        chk("nack",       rq, int'(resp_nack),  int'(vec[15]));
        chk("state",      rq, int'(resp_state), int'(vec[14:13]));
        chk("c2c",        rq, int'(resp_c2c),   int'(vec[12]));
        chk("revoke",     rq, int'(revoke_o),   int'(vec[11:8]));
        chk("abort",      rq, int'(abort_o),    int'(vec[7:4]));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("ready in reset", 12, int'(req_ready), 0);
        chk("valid in reset", 12, int'(resp_valid), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("ready after reset", 12, int'(req_ready), 1);
        chk("abort after reset", 12, int'(abort_o), 0);
        chk("revoke after reset", 12, int'(revoke_o), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        nack_mode = 1'b0;
        do_reset();
        for (int i = 0; i < 21; i++) apply(TAB_RW[i]);

        // R11: pulse is one cycle, nothing without a request
        @(negedge clk);
        chk("idle resp_valid", 11, int'(resp_valid), 0);
        chk("idle abort", 11, int'(abort_o), 0);

        // R12: reset clears every line (L3 was M by core 1)
        do_reset();
        apply(v(0,0,3,0, 1,0,1,0,4'b0000,4'b0000, 12));

        // R10: requestor-win rollback of the holder elsewhere
        apply(v(1,1,11,1, 1,0,2,0,4'b0000,4'b0000, 3));
        apply(v(0,1,12,1, 1,0,1,0,4'b0000,4'b0000, 1));
        apply(v(0,2,11,0, 1,0,1,0,4'b0010,4'b0010, 4));
        apply(v(1,3,12,0, 1,0,2,0,4'b0010,4'b0000, 10)); // S flag dropped

        nack_mode = 1'b1;
        do_reset();
        for (int i = 0; i < 9; i++) apply(TAB_NK[i]);
        @(negedge clk);
        chk("idle abort nack", 11, int'(abort_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule